// File: doc/BRIEF.md
# I2C Message Sequencer

This block drives a status-coded I2C byte engine through one whole message, either a read or a write, with no processor involvement. A requester gives it a target address (7 or 10 bits wide), a direction, a byte count and, for writes, a byte stream. The sequencer then reacts to every event the engine reports. It reads the engine's 8-bit status code and issues exactly one next action: START, first or second address byte, transmit byte, continue (arm a receive), receive, receive-then-STOP, or STOP.

The sequencer forms the address bytes itself. In 10-bit mode the first byte is `0xF0 | (addr[9:8] << 1) | dir` and the second is `addr[7:0]`. In 7-bit mode the only address byte is `(addr[6:0] << 1) | dir`, with read = 1. The ACK-enable flag is dropped at the right moment so that the engine NACKs the last byte of a read. A read of zero bytes ends as soon as the address is acknowledged, which makes it a presence probe. An abort request ends a write after the byte in flight and makes a read NACK its next byte.

When the message ends, a one-cycle done pulse comes with a result code. Every output is a register that updates on the clock edge after the stimulus that caused it.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset, act_valid, wr_pop, rd_valid, done, eng_reinit, act_ack_en, act_ctl_en and result are all 0, and the sequencer is idle.
- R2: A req_start while idle gives, one cycle later, act_valid with act_code 0 (START), act_ack_en = 1 and act_ctl_en = 1. It loads the count and clears the byte position and the abort flag. A req_start while busy produces no action and changes nothing.
- R3: On status 0x08 or 0x10 the action is code 1 (first address byte) with act_byte = `(addr[6:0]<<1)|rd` in 7-bit mode, or `0xF0|(addr[9:8]<<1)|rd` in 10-bit mode.
- R4: On status 0x18 or 0x40 in 10-bit mode the action is code 2 (second address byte) with act_byte = addr[7:0].
- R5: On a write acknowledge (0xD0, 0x28, or 0x18 in 7-bit mode) with bytes remaining, the action is code 3 (transmit) with act_byte = wr_data and a wr_pop pulse, and the count drops by one. With no bytes remaining, the action is code 7 (STOP), and done pulses with result 0 (ok).
- R6: abort_req while busy sets an abort flag. A write acknowledge that arrives while the flag is set and after at least one byte was sent ends the message with STOP, done and result 0.
- R7: On a read address acknowledge (0xE0, or 0x40 in 7-bit mode) with a count of zero, the action is STOP with done and result 0. With a count above zero, the action is code 4 (continue).
- R8: On status 0x50 the action is code 5 (receive) with rd_valid and rd_data = evt_rxdata, and the count drops by one, saturating at 0. act_ack_en falls to 0 and stays 0 for the rest of the message once the count, after any drop, equals 1 or the abort flag is set. This is checked on 0x50 and on a read address acknowledge.
- R9: On status 0x58 the action is code 6 (receive-then-STOP) with rd_valid, rd_data = evt_rxdata, done and result 0.
- R10: Status 0x20, 0x30 or 0x48 ends the message with STOP, done and result 1 (no device).
- R11: Any other status ends the message with STOP, done, result 2 (controller error) and an eng_reinit pulse.
- R12: An engine event while idle gives a STOP action with no done, no wr_pop, no rd_valid and no change of state.
- R13: The sequencer issues at most one action per event, one cycle after the event or start. No action appears in a cycle with neither. done pulses in the same cycle as the final action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Begin a message (accepted only while idle) |
| req_addr | input | 10 | Target address |
| req_ten | input | 1 | 1 = 10-bit address mode |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Number of data bytes |
| abort_req | input | 1 | Ask for early termination of the running message |
| wr_data | input | 8 | Next write byte, taken when wr_pop pulses |
| wr_pop | output | 1 | Write byte consumed |
| evt_valid | input | 1 | Engine event present |
| evt_status | input | 8 | Engine status code |
| evt_rxdata | input | 8 | Byte received by the engine |
| act_valid | output | 1 | Action command to the engine |
| act_code | output | 3 | 0 START, 1 addr1, 2 addr2, 3 send, 4 continue, 5 receive, 6 receive+STOP, 7 STOP |
| act_byte | output | 8 | Byte to load for codes 1..3, else 0 |
| act_ack_en | output | 1 | ACK-enable control bit |
| act_ctl_en | output | 1 | Controller-enable control bit |
| eng_reinit | output | 1 | Engine reinitialisation pulse |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Message finished |
| result | output | 2 | 0 ok, 1 no device, 2 controller error |

## Verification
Directed messages cover 7-bit and 10-bit writes, 10-bit reads, zero-length probes, aborted writes and reads, refusals and stray codes. They separate the address forming and the path chosen from each status code, and show when the ACK-enable falls. Random runs feed random status streams, including illegal codes, codes out of order and codes that arrive while idle, with random aborts. These runs compare every action, strobe and result against a requirement-level model. That exposes wrong decoding of any code, a missing counter saturation, and abort or idle handling that does not match.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_START, ST_WAIT_A1, ST_WAIT_A2, ST_WAIT_TACK, ST_WAIT_RDATA
  } seq_state_t;

  typedef enum logic [2:0] {
    ACT_START = 3'd0, ACT_ADDR1 = 3'd1, ACT_ADDR2 = 3'd2, ACT_SEND = 3'd3,
    ACT_CONT = 3'd4, ACT_RECV = 3'd5, ACT_RECV_STOP = 3'd6, ACT_STOP = 3'd7
  } seq_act_t;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_NODEV = 2'd1, RES_ERR = 2'd2
  } seq_res_t;

  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RSTART   = 8'h10;
  localparam logic [7:0] SC_WA_ACK   = 8'h18;
  localparam logic [7:0] SC_WA_NACK  = 8'h20;
  localparam logic [7:0] SC_WD_ACK   = 8'h28;
  localparam logic [7:0] SC_WD_NACK  = 8'h30;
  localparam logic [7:0] SC_RA_ACK   = 8'h40;
  localparam logic [7:0] SC_RA_NACK  = 8'h48;
  localparam logic [7:0] SC_RD_ACK   = 8'h50;
  localparam logic [7:0] SC_RD_NACK  = 8'h58;
  localparam logic [7:0] SC_WA2_ACK  = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK  = 8'hE0;

  typedef struct packed {
    seq_state_t        nxt;
    seq_act_t          act;
    logic [BYTE_W-1:0] byte_out;
    logic              pop;
    logic              rd;
    logic              fin;
    seq_res_t          res;
    logic              reinit;
    logic              clr_ack;
    logic              step;
  } seq_dec_t;
endpackage

// File: rtl/i2c_seq_addr_form.sv
`timescale 1ns/1ps
module i2c_seq_addr_form
  import i2c_seq_pkg::*;
(
  input  logic [ADR_W-1:0]  addr,
  input  logic              ten,
  input  logic              rd,
  output logic [BYTE_W-1:0] first_byte,
  output logic [BYTE_W-1:0] second_byte
);
  always_comb begin
    if (ten) begin
      first_byte  = 8'hF0 | {5'd0, addr[9:8], 1'b0} | {7'd0, rd};
      second_byte = addr[7:0];
    end else begin
      first_byte  = {addr[6:0], rd};
      second_byte = '0;
    end
  end
endmodule

// File: rtl/i2c_seq_decode.sv
`timescale 1ns/1ps
module i2c_seq_decode
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
)(
  input  seq_state_t        cur_state,
  input  logic [7:0]        status,
  input  logic              ten,
  input  logic [LEN_W-1:0]  rem,
  input  logic              pos_nz,
  input  logic              aborting,
  input  logic [BYTE_W-1:0] a1,
  input  logic [BYTE_W-1:0] a2,
  input  logic [BYTE_W-1:0] wr_byte,
  output seq_dec_t          d,
  output logic [LEN_W-1:0]  rem_next
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic is_idle, is_start, is_a2, is_wr_ack, is_rd_addr, is_nodev;
  logic [LEN_W-1:0] rem_dec;

  always_comb begin
    is_idle    = (cur_state == ST_IDLE);
    is_start   = (status == SC_START) || (status == SC_RSTART);
    is_a2      = ten && ((status == SC_WA_ACK) || (status == SC_RA_ACK));
    is_wr_ack  = (status == SC_WA2_ACK) || (status == SC_WD_ACK) ||
                 (!ten && (status == SC_WA_ACK));
    is_rd_addr = (status == SC_RA2_ACK) || (!ten && (status == SC_RA_ACK));
    is_nodev   = (status == SC_WA_NACK) || (status == SC_WD_NACK) ||
                 (status == SC_RA_NACK);
    rem_dec    = (rem == '0) ? '0 : rem - ONE;
  end

  always_comb begin
    d        = '0;
    d.nxt    = cur_state;
    d.act    = ACT_STOP;
    d.res    = RES_OK;
    rem_next = rem;
    if (is_idle) begin
      d.nxt = ST_IDLE;
    end else if (is_start) begin
      d.act      = ACT_ADDR1;
      d.byte_out = a1;
      d.nxt      = ST_WAIT_A1;
    end else if (is_a2) begin
      d.act      = ACT_ADDR2;
      d.byte_out = a2;
      d.nxt      = ST_WAIT_A2;
    end else if (is_wr_ack) begin
      if ((rem == '0) || (aborting && pos_nz)) begin
        d.nxt = ST_IDLE;
        d.fin = 1'b1;
      end else begin
        d.act      = ACT_SEND;
        d.byte_out = wr_byte;
        d.pop      = 1'b1;
        d.step     = 1'b1;
        d.nxt      = ST_WAIT_TACK;
        rem_next   = rem_dec;
      end
    end else if (is_rd_addr) begin
      if (rem == '0) begin
        d.nxt = ST_IDLE;
        d.fin = 1'b1;
      end else begin
        d.act     = ACT_CONT;
        d.nxt     = ST_WAIT_RDATA;
        d.clr_ack = (rem == ONE) || aborting;
      end
    end else if (status == SC_RD_ACK) begin
      d.act     = ACT_RECV;
      d.rd      = 1'b1;
      d.step    = 1'b1;
      d.nxt     = ST_WAIT_RDATA;
      rem_next  = rem_dec;
      d.clr_ack = (rem_dec == ONE) || aborting;
    end else if (status == SC_RD_NACK) begin
      d.act    = ACT_RECV_STOP;
      d.rd     = 1'b1;
      d.step   = 1'b1;
      d.fin    = 1'b1;
      d.nxt    = ST_IDLE;
      rem_next = rem_dec;
    end else if (is_nodev) begin
      d.fin = 1'b1;
      d.res = RES_NODEV;
      d.nxt = ST_IDLE;
    end else begin
      d.fin    = 1'b1;
      d.res    = RES_ERR;
      d.reinit = 1'b1;
      d.nxt    = ST_IDLE;
    end
  end
endmodule

// File: rtl/i2c_msg_sequencer.sv
`timescale 1ns/1ps
module i2c_msg_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic [9:0]       req_addr,
  input  logic             req_ten,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic             abort_req,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  input  logic             evt_valid,
  input  logic [7:0]       evt_status,
  input  logic [7:0]       evt_rxdata,
  output logic             act_valid,
  output logic [2:0]       act_code,
  output logic [7:0]       act_byte,
  output logic             act_ack_en,
  output logic             act_ctl_en,
  output logic             eng_reinit,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [1:0]       result
);
  seq_state_t        state_q;
  seq_act_t          act_q;
  seq_res_t          res_q;
  logic              ten_q, abort_q;
  logic [LEN_W-1:0]  rem_q, pos_q, rem_nxt;
  logic [BYTE_W-1:0] a1_q, a2_q, a1_w, a2_w;
  seq_dec_t          dec;

  i2c_seq_addr_form u_addr (
    .addr        (req_addr),
    .ten         (req_ten),
    .rd          (req_read),
    .first_byte  (a1_w),
    .second_byte (a2_w)
  );

  i2c_seq_decode #(.LEN_W(LEN_W)) u_dec (
    .cur_state (state_q),
    .status    (evt_status),
    .ten       (ten_q),
    .rem       (rem_q),
    .pos_nz    (pos_q != '0),
    .aborting  (abort_q),
    .a1        (a1_q),
    .a2        (a2_q),
    .wr_byte   (wr_data),
    .d         (dec),
    .rem_next  (rem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      act_q      <= ACT_START;
      res_q      <= RES_OK;
      ten_q      <= 1'b0;
      abort_q    <= 1'b0;
      rem_q      <= '0;
      pos_q      <= '0;
      a1_q       <= '0;
      a2_q       <= '0;
      act_valid  <= 1'b0;
      act_byte   <= '0;
      act_ack_en <= 1'b0;
      act_ctl_en <= 1'b0;
      wr_pop     <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      eng_reinit <= 1'b0;
    end else begin
      act_valid  <= 1'b0;
      wr_pop     <= 1'b0;
      rd_valid   <= 1'b0;
      done       <= 1'b0;
      eng_reinit <= 1'b0;
      if (evt_valid) begin
        state_q    <= dec.nxt;
        act_valid  <= 1'b1;
        act_q      <= dec.act;
        act_byte   <= dec.byte_out;
        wr_pop     <= dec.pop;
        rd_valid   <= dec.rd;
        done       <= dec.fin;
        eng_reinit <= dec.reinit;
        if (dec.rd) rd_data <= evt_rxdata;
        if (dec.fin) res_q <= dec.res;
        if (dec.clr_ack) act_ack_en <= 1'b0;
        if (dec.step) begin
          rem_q <= rem_nxt;
          pos_q <= pos_q + LEN_W'(1);
        end
        if (state_q != ST_IDLE && abort_req) abort_q <= 1'b1;
      end else if (state_q == ST_IDLE) begin
        if (req_start) begin
          state_q    <= ST_WAIT_START;
          act_valid  <= 1'b1;
          act_q      <= ACT_START;
          act_byte   <= '0;
          act_ack_en <= 1'b1;
          act_ctl_en <= 1'b1;
          rem_q      <= req_len;
          pos_q      <= '0;
          abort_q    <= 1'b0;
          ten_q      <= req_ten;
          a1_q       <= a1_w;
          a2_q       <= a2_w;
        end
      end else if (abort_req) begin
        abort_q <= 1'b1;
      end
    end
  end

  assign act_code = act_q;
  assign result   = res_q;
endmodule

// File: rtl/i2c_seq_chk.sv
`timescale 1ns/1ps
module i2c_seq_chk
  import i2c_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       is_idle,
  input logic       req_start,
  input logic       evt_valid,
  input logic       act_valid,
  input logic [2:0] act_code,
  input logic       act_ack_en,
  input logic       wr_pop,
  input logic       rd_valid,
  input logic       done,
  input logic [1:0] result,
  input logic       eng_reinit
);
  // R5: a consumed write byte always travels with a transmit action
  assert_pop_send_R5: assert property (@(posedge clk) disable iff (rst)
    wr_pop |-> (act_valid && act_code == ACT_SEND));

  // R8 / R9: received byte strobe only with a receive action
  assert_rd_recv_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (act_valid && (act_code == ACT_RECV || act_code == ACT_RECV_STOP)));

  assert_done_final_R13: assert property (@(posedge clk) disable iff (rst)
    done |-> (act_valid && (act_code == ACT_STOP || act_code == ACT_RECV_STOP)));

  assert_reinit_err_R11: assert property (@(posedge clk) disable iff (rst)
    eng_reinit |-> (done && result == RES_ERR));

  assert_idle_evt_R12: assert property (@(posedge clk) disable iff (rst)
    (is_idle && evt_valid) |=> (act_valid && act_code == ACT_STOP && !done && !rd_valid));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (is_idle && req_start && !evt_valid) |=> (act_valid && act_code == ACT_START && act_ack_en));

  assert_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && !(is_idle && req_start)) |=> !act_valid);

  assert_ack_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(act_ack_en) |-> (act_valid && (act_code == ACT_CONT || act_code == ACT_RECV)));

  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_pop, rd_valid}));
endmodule

bind i2c_msg_sequencer i2c_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .is_idle    (state_q == i2c_seq_pkg::ST_IDLE),
  .req_start  (req_start),
  .evt_valid  (evt_valid),
  .act_valid  (act_valid),
  .act_code   (act_code),
  .act_ack_en (act_ack_en),
  .wr_pop     (wr_pop),
  .rd_valid   (rd_valid),
  .done       (done),
  .result     (result),
  .eng_reinit (eng_reinit)
);

// File: tb/i2c_msg_sequencer_tb.sv
`timescale 1ns/1ps
module i2c_msg_sequencer_tb;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 0, req_ten = 0, req_read = 0, abort_req = 0, evt_valid = 0;
  logic [9:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data = '0, evt_status = '0, evt_rxdata = '0;
  logic wr_pop, act_valid, act_ack_en, act_ctl_en, eng_reinit, rd_valid, done;
  logic [2:0] act_code;
  logic [7:0] act_byte, rd_data;
  logic [1:0] result;

  always #10 clk = ~clk;

  i2c_msg_sequencer #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_ten(req_ten), .req_read(req_read), .req_len(req_len),
    .abort_req(abort_req), .wr_data(wr_data), .wr_pop(wr_pop),
    .evt_valid(evt_valid), .evt_status(evt_status), .evt_rxdata(evt_rxdata),
    .act_valid(act_valid), .act_code(act_code), .act_byte(act_byte),
    .act_ack_en(act_ack_en), .act_ctl_en(act_ctl_en), .eng_reinit(eng_reinit),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .result(result)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // requirement-level model
  bit m_busy, m_ten, m_abort, m_ack, m_ctl;
  logic [7:0] m_a1, m_a2;
  logic [LEN_W-1:0] m_rem, m_pos;
  logic [7:0] wbuf [16];
  bit e_valid, e_pop, e_rd, e_done, e_reinit;
  logic [2:0] e_code;
  logic [7:0] e_byte, e_rdd;
  logic [1:0] e_res;

  task automatic clr_exp();
    e_valid = 0; e_pop = 0; e_rd = 0; e_done = 0; e_reinit = 0;
    e_code = 3'd7; e_byte = 0; e_rdd = 0; e_res = 0;
  endtask

  task automatic finish_msg(input logic [1:0] res);
    e_code = 3'd7; e_done = 1; e_res = res; m_busy = 0;
  endtask

  task automatic wr_ack_path();
    if (m_rem == 0 || (m_abort && m_pos != 0)) finish_msg(2'd0);
    else begin
      e_code = 3'd3; e_byte = wbuf[m_pos[3:0]]; e_pop = 1;
      m_rem = m_rem - 1; m_pos = m_pos + 1;
    end
  endtask

  task automatic rd_addr_path();
    if (m_rem == 0) finish_msg(2'd0);
    else begin
      e_code = 3'd4;
      if (m_rem == 1 || m_abort) m_ack = 0;
    end
  endtask

  task automatic model_evt(input logic [7:0] st, input logic [7:0] rx);
    clr_exp();
    e_valid = 1;
    if (!m_busy) e_code = 3'd7;
    else case (st)
      8'h08, 8'h10: begin e_code = 3'd1; e_byte = m_a1; end
      8'h18: if (m_ten) begin e_code = 3'd2; e_byte = m_a2; end else wr_ack_path();
      8'h40: if (m_ten) begin e_code = 3'd2; e_byte = m_a2; end else rd_addr_path();
      8'hD0, 8'h28: wr_ack_path();
      8'hE0: rd_addr_path();
      8'h50: begin
        e_code = 3'd5; e_rd = 1; e_rdd = rx;
        if (m_rem != 0) m_rem = m_rem - 1;
        m_pos = m_pos + 1;
        if (m_rem == 1 || m_abort) m_ack = 0;
      end
      8'h58: begin
        e_rd = 1; e_rdd = rx;
        if (m_rem != 0) m_rem = m_rem - 1;
        m_pos = m_pos + 1;
        finish_msg(2'd0); e_code = 3'd6;
      end
      8'h20, 8'h30, 8'h48: finish_msg(2'd1);
      default: begin finish_msg(2'd2); e_reinit = 1; end
    endcase
  endtask

  task automatic compare(input string tag);
    bit bad;
    n_tests++;
    bad = (act_valid !== e_valid) || (wr_pop !== e_pop) || (rd_valid !== e_rd) ||
          (done !== e_done) || (eng_reinit !== e_reinit) ||
          (act_ack_en !== m_ack) || (act_ctl_en !== m_ctl);
    if (e_valid && act_code !== e_code) bad = 1;
    if (e_valid && (e_code inside {3'd1, 3'd2, 3'd3}) && act_byte !== e_byte) bad = 1;
    if (e_rd && rd_data !== e_rdd) bad = 1;
    if (e_done && result !== e_res) bad = 1;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: act v=%0b c=%0d b=%02h ack=%0b ctl=%0b pop=%0b rd=%0b/%02h done=%0b res=%0d ri=%0b | exp v=%0b c=%0d b=%02h ack=%0b ctl=%0b pop=%0b rd=%0b/%02h done=%0b res=%0d ri=%0b",
        tag, act_valid, act_code, act_byte, act_ack_en, act_ctl_en, wr_pop, rd_valid, rd_data,
        done, result, eng_reinit, e_valid, e_code, e_byte, m_ack, m_ctl, e_pop, e_rd, e_rdd,
        e_done, e_res, e_reinit);
    end
  endtask

  function automatic string tag_of(input logic [7:0] st);
    if (!m_busy) return "R12";
    case (st)
      8'h08, 8'h10: return "R3";
      8'h18: return m_ten ? "R4" : "R5";
      8'h40: return m_ten ? "R4" : "R7";
      8'hD0, 8'h28: return (m_abort && m_pos != 0) ? "R6" : "R5";
      8'hE0: return "R7";
      8'h50: return "R8";
      8'h58: return "R9";
      8'h20, 8'h30, 8'h48: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic evt(input logic [7:0] st, input logic [7:0] rx);
    string tag;
    @(negedge clk);
    tag = tag_of(st);
    wr_data = wbuf[m_pos[3:0]];
    evt_status = st; evt_rxdata = rx; evt_valid = 1;
    model_evt(st, rx);
    @(posedge clk); #1;
    evt_valid = 0;
    compare(tag);
  endtask

  task automatic start(input logic [9:0] addr, input bit ten, input bit rd,
                       input logic [LEN_W-1:0] len);
    @(negedge clk);
    req_addr = addr; req_ten = ten; req_read = rd; req_len = len; req_start = 1;
    clr_exp();
    if (!m_busy) begin
      e_valid = 1; e_code = 3'd0;
      m_busy = 1; m_ten = ten; m_abort = 0; m_ack = 1; m_ctl = 1;
      m_rem = len; m_pos = 0;
      m_a1 = ten ? (8'hF0 | {5'd0, addr[9:8], 1'b0} | {7'd0, rd}) : {addr[6:0], rd};
      m_a2 = ten ? addr[7:0] : 8'h00;
    end
    @(posedge clk); #1;
    req_start = 0;
    compare("R2");
  endtask

  task automatic abort_now();
    @(negedge clk);
    abort_req = 1;
    clr_exp();
    if (m_busy) m_abort = 1;
    @(posedge clk); #1;
    abort_req = 0;
    compare("R6");
  endtask

  task automatic quiet();
    @(negedge clk);
    clr_exp();
    @(posedge clk); #1;
    compare("R13");
  endtask

  localparam int NSC = 16;
  function automatic logic [7:0] pick_status(input int k);
    case (k)
      0: return 8'h08;  1: return 8'h10;  2: return 8'h18;  3: return 8'h40;
      4: return 8'hD0;  5: return 8'h28;  6: return 8'hE0;  7: return 8'h50;
      8: return 8'h58;  9: return 8'h20;  10: return 8'h30; 11: return 8'h48;
      12: return 8'h38; 13: return 8'h00; 14: return 8'h28; default: return 8'h50;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R13: watchdog expired act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h30 + 8'(i * 7);
    m_busy = 0; m_ack = 0; m_ctl = 0; m_abort = 0; m_ten = 0;
    m_rem = 0; m_pos = 0; m_a1 = 0; m_a2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    @(negedge clk);
    n_tests++;
    if (act_valid || wr_pop || rd_valid || done || eng_reinit || act_ack_en ||
        act_ctl_en || result != 0) begin
      n_fail++;
      $display("FAIL R1: outputs v=%0b ack=%0b ctl=%0b done=%0b res=%0d exp all 0",
               act_valid, act_ack_en, act_ctl_en, done, result);
    end
    quiet();
    // R12 events while idle
    evt(8'h08, 8'h00);
    evt(8'h58, 8'h11);
    // 7-bit write of two bytes, start while busy ignored
    start(10'h050, 0, 0, 2);
    start(10'h3FF, 1, 1, 9);
    evt(8'h08, 0);
    evt(8'h18, 0);
    quiet();
    evt(8'h28, 0);
    evt(8'h28, 0);
    // 10-bit read of three bytes
    start(10'h2B5, 1, 1, 3);
    evt(8'h10, 0);
    evt(8'h40, 0);
    evt(8'hE0, 0);
    evt(8'h50, 8'hA1);
    evt(8'h50, 8'hB2);
    evt(8'h58, 8'hC3);
    // R7 probe
    start(10'h03C, 0, 1, 0);
    evt(8'h08, 0);
    evt(8'h40, 0);
    // R6 aborted write after a byte
    start(10'h011, 0, 0, 4);
    evt(8'h08, 0);
    evt(8'h18, 0);
    abort_now();
    evt(8'h28, 0);
    // abort before any byte: first byte still sent
    start(10'h022, 0, 0, 2);
    abort_now();
    evt(8'h08, 0);
    evt(8'h18, 0);
    evt(8'h28, 0);
    // R8 aborted read clears ACK at once
    start(10'h044, 0, 1, 4);
    evt(8'h08, 0);
    abort_now();
    evt(8'h40, 0);
    evt(8'h58, 8'h5A);
    // R10 and R11
    start(10'h055, 0, 0, 1);
    evt(8'h08, 0);
    evt(8'h20, 0);
    start(10'h056, 0, 1, 1);
    evt(8'h08, 0);
    evt(8'h48, 0);
    start(10'h057, 0, 0, 3);
    evt(8'h08, 0);
    evt(8'h18, 0);
    evt(8'h30, 0);
    start(10'h058, 0, 0, 1);
    evt(8'h08, 0);
    evt(8'h38, 0);
    // 10-bit write
    start(10'h1C3, 1, 0, 1);
    evt(8'h08, 0);
    evt(8'h18, 0);
    evt(8'hD0, 0);
    evt(8'h28, 0);
    // random streams
    for (int t = 0; t < 300; t++) begin
      start(10'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), LEN_W'($urandom_range(0, 5)));
      for (int k = 0; k < 10 && m_busy; k++) begin
        if ($urandom_range(0, 15) == 0) abort_now();
        if ($urandom_range(0, 7) == 0) quiet();
        evt(pick_status($urandom_range(0, NSC - 1)), 8'($urandom_range(0, 255)));
      end
      if (m_busy) evt(8'h20, 0);
      if ($urandom_range(0, 5) == 0) evt(pick_status($urandom_range(0, NSC - 1)), 8'h77);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule